// File: doc/BRIEF.md
# Ping-Pong Output DMA Pointer Controller

This block feeds a streaming sample output from memory through two alternating buffers. Software gives it the start address of the buffer now playing and, ahead of time, the start address of the next one. The block fetches 16-bit samples one at a time over a request/acknowledge read port and holds them in a small two-entry queue for a downstream consumer. When the last sample of the active buffer has been fetched, the queued-up pointer becomes active, its register goes back to zero, and a sticky handoff flag is raised so that software can supply the following pointer.

Bring-up is a three-write sequence. The first pointer write (in `IDLE`) names the first buffer and moves to `ARMED`. The size write (in `ARMED`) starts fetching (`FETCH`) and fills the queue with two samples before any consumption. The second pointer write fills the pending slot. While running, the machine moves between `FETCH` (request outstanding) and `WAIT` (queue full, waiting for the consumer). If a buffer finishes while no pointer is pending, the machine enters `HALT`: the error flag is set, the outputs go inactive and the queue is dropped. Clearing the error flag returns to `IDLE`, and the full bring-up is needed again. The named transitions are: IDLE→ARMED (nonzero pointer write), ARMED→FETCH (nonzero size write), FETCH→WAIT (acknowledge, with or without handoff), FETCH→HALT (acknowledge of the last sample with no pointer pending), WAIT→FETCH (queue has room), and HALT→IDLE (error flag cleared).

Top module: `pp_dma_ptr_ctrl`

## Requirements
- R1: After reset the machine is in IDLE. The pending pointer, the size and both flags read zero. `mem_req`, `out_en` and `smp_valid` are low.
- R2: Register select 0 is the 32-bit next-pointer register, and all 32 bits are the pointer. Outside IDLE and HALT, a read returns the last value written until that value is promoted.
- R3: On the acknowledge of the final sample of a buffer with a nonzero pending pointer, the active address takes the pending value and the sample count restarts. The next-pointer register then reads zero (unless it is written in that same cycle), and the next request goes to the new pointer.
- R4: Register select 2 holds the flags: bit 0 is handoff and bit 1 is error. Each handoff sets bit 0. Flags are sticky and are cleared by writing one to their bit. A set wins over a clear in the same cycle. `irq_handoff` and `irq_err` mirror bits 0 and 1.
- R5: In IDLE, a nonzero write to select 0 loads the active address and leaves the pending register at zero (IDLE→ARMED). A zero write is ignored. In ARMED, a write to select 1 whose low 16 bits are nonzero starts fetching (ARMED→FETCH).
- R6: After the size write, two samples are fetched, from the first pointer and from that pointer plus 2, with no consumption needed.
- R7: Each acknowledged fetch advances the active address by 2 bytes. A buffer of N samples is read from N consecutive sample addresses.
- R8: A request stays high with a stable address until it is acknowledged. After an acknowledge the request drops for at least one cycle. A new request is raised only when the two-entry queue has room.
- R9: If the final sample of a buffer is acknowledged while the pending pointer is zero (a write in that same cycle counts as late), the error flag sets, the machine enters HALT, and `out_en`, `smp_valid` and `mem_req` go low with the queue emptied.
- R10: In HALT, pointer and size writes have no effect. Clearing the error flag moves to IDLE, and the outputs stay off until the bring-up sequence is repeated.
- R11: Writes to select 1 take effect only in IDLE and ARMED. Select 1 reads back the 16-bit size, zero-extended.
- R12: `smp_valid` is high when running (FETCH or WAIT) with a nonempty queue. `smp_data` is the oldest fetched sample, and it is removed in a cycle where `smp_take` and `smp_valid` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 2 | Write select: 0 pointer, 1 size, 2 flags |
| reg_wr_data | input | 32 | Write data |
| reg_rd_addr | input | 2 | Read select |
| reg_rd_data | output | 32 | Read data, combinational from the select |
| mem_req | output | 1 | Sample fetch request |
| mem_addr | output | 32 | Byte address of the requested sample |
| mem_ack | input | 1 | Fetch acknowledge with data |
| mem_rdata | input | 16 | Fetched sample |
| smp_take | input | 1 | Consumer takes the presented sample |
| smp_valid | output | 1 | A sample is presented |
| smp_data | output | 16 | Presented sample |
| out_en | output | 1 | Output enable, low in IDLE, ARMED and HALT |
| irq_handoff | output | 1 | Sticky handoff flag |
| irq_err | output | 1 | Sticky pointer error flag |

## Verification
Register writes take effect at the next clock edge, and reads are combinational from the select. A size write in ARMED raises `mem_req` one edge later. An acknowledge shows up in the flags, the pending register and `smp_valid` one edge later, and it lowers `mem_req` for at least one cycle. The bench steps a queue-based reference model at each rising edge with the same inputs. It then compares every output half a period later, so every result is checked exactly one register stage after its cause. Directed reads are placed after the writing edge and around each handoff, so that the pointer readback is seen both before and after promotion.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_FETCH,
        ST_WAIT,
        ST_HALT
    } dma_state_e;

    localparam logic [1:0] RA_NEXT  = 2'd0;
    localparam logic [1:0] RA_SIZE  = 2'd1;
    localparam logic [1:0] RA_FLAGS = 2'd2;

    localparam int FLAG_HANDOFF = 0;
    localparam int FLAG_ERR     = 1;
endpackage

// File: rtl/pp_dma_smp_fifo.sv
module pp_dma_smp_fifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 2,
    parameter int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic [LVL_W-1:0]  level
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] slot_q [DEPTH];
    logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
    logic [LVL_W-1:0]  level_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_SLOT) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            level_q  <= '0;
        end else begin
            if (push) wr_ptr_q <= bump(wr_ptr_q);
            if (pop)  rd_ptr_q <= bump(rd_ptr_q);
            unique case ({push, pop})
                2'b10:   level_q <= level_q + LVL_W'(1);
                2'b01:   level_q <= level_q - LVL_W'(1);
                default: level_q <= level_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push && !flush) slot_q[wr_ptr_q] <= wdata;
    end

    assign rdata = slot_q[rd_ptr_q];
    assign level = level_q;
endmodule

// File: rtl/pp_dma_regfile.sv
module pp_dma_regfile
    import pp_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    input  dma_state_e        state,
    input  logic              ho_pulse,
    input  logic              err_pulse,
    output logic [ADDR_W-1:0] rd_data,
    output logic [ADDR_W-1:0] pend_q,
    output logic [SIZE_W-1:0] size_q,
    output logic [1:0]        flags_q
);
    logic       wr_next, wr_size, wr_flags;
    logic       pend_open, size_open;
    logic [1:0] clr_bits, set_bits;

    assign wr_next   = wr_en && (wr_sel == RA_NEXT);
    assign wr_size   = wr_en && (wr_sel == RA_SIZE);
    assign wr_flags  = wr_en && (wr_sel == RA_FLAGS);
    assign pend_open = (state != ST_IDLE) && (state != ST_HALT);
    assign size_open = (state == ST_IDLE) || (state == ST_ARMED);
    assign clr_bits  = wr_flags ? wr_data[1:0] : 2'b00;
    assign set_bits  = {err_pulse, ho_pulse};

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= '0;
            size_q  <= '0;
            flags_q <= '0;
        end else begin
            if (err_pulse)
                pend_q <= '0;
            else if (wr_next && pend_open)
                pend_q <= wr_data;
            else if (ho_pulse)
                pend_q <= '0;

            if (wr_size && size_open)
                size_q <= wr_data[SIZE_W-1:0];

            flags_q <= (flags_q & ~clr_bits) | set_bits;
        end
    end

    always_comb begin
        unique case (rd_sel)
            RA_NEXT:  rd_data = pend_q;
            RA_SIZE:  rd_data = {{(ADDR_W-SIZE_W){1'b0}}, size_q};
            RA_FLAGS: rd_data = {{(ADDR_W-2){1'b0}}, flags_q};
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/pp_dma_fetch_fsm.sv
module pp_dma_fetch_fsm
    import pp_dma_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int SIZE_W       = 16,
    parameter int DEPTH        = 2,
    parameter int SAMPLE_BYTES = 2,
    parameter int LVL_W        = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] pend_q,
    input  logic [SIZE_W-1:0] size_q,
    input  logic              err_flag,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic              mem_ack,
    output dma_state_e        state,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              out_en,
    output logic              push,
    output logic              ho_pulse,
    output logic              err_pulse
);
    localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(SAMPLE_BYTES);
    localparam logic [LVL_W-1:0]  FULL_LVL  = LVL_W'(DEPTH);

    dma_state_e        st_q, st_d;
    logic [ADDR_W-1:0] act_q;
    logic [SIZE_W-1:0] cnt_q;
    logic              wr_next, wr_size, beat, last;

    assign wr_next   = wr_en && (wr_sel == RA_NEXT);
    assign wr_size   = wr_en && (wr_sel == RA_SIZE);
    assign beat      = (st_q == ST_FETCH) && mem_ack;
    assign last      = (cnt_q == size_q - SIZE_W'(1));
    assign ho_pulse  = beat && last && (pend_q != '0);
    assign err_pulse = beat && last && (pend_q == '0);
    assign push      = beat && !err_pulse;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (wr_next && (wr_data != '0))            st_d = ST_ARMED;
            ST_ARMED: if (wr_size && (wr_data[SIZE_W-1:0] != '0)) st_d = ST_FETCH;
            ST_FETCH: if (mem_ack)                                st_d = err_pulse ? ST_HALT : ST_WAIT;
            ST_WAIT:  if (fifo_level < FULL_LVL)                  st_d = ST_FETCH;
            ST_HALT:  if (!err_flag)                              st_d = ST_IDLE;
            default:                                              st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
            cnt_q <= '0;
        end else if (st_q == ST_IDLE && st_d == ST_ARMED) begin
            act_q <= wr_data;
            cnt_q <= '0;
        end else if (st_q == ST_ARMED && st_d == ST_FETCH) begin
            cnt_q <= '0;
        end else if (beat) begin
            if (last) begin
                act_q <= pend_q;
                cnt_q <= '0;
            end else begin
                act_q <= act_q + ADDR_STEP;
                cnt_q <= cnt_q + SIZE_W'(1);
            end
        end
    end

    always_comb begin
        mem_req  = 1'b0;
        out_en   = 1'b0;
        mem_addr = act_q;
        unique case (st_q)
            ST_FETCH: begin
                mem_req = 1'b1;
                out_en  = 1'b1;
            end
            ST_WAIT:  out_en = 1'b1;
            default:  ;
        endcase
    end

    assign state = st_q;
endmodule

// File: rtl/pp_dma_ptr_ctrl.sv
module pp_dma_ptr_ctrl
    import pp_dma_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int SIZE_W       = 16,
    parameter int DATA_W       = 16,
    parameter int DEPTH        = 2,
    parameter int SAMPLE_BYTES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_wr_addr,
    input  logic [ADDR_W-1:0] reg_wr_data,
    input  logic [1:0]        reg_rd_addr,
    output logic [ADDR_W-1:0] reg_rd_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              smp_take,
    output logic              smp_valid,
    output logic [DATA_W-1:0] smp_data,
    output logic              out_en,
    output logic              irq_handoff,
    output logic              irq_err
);
    localparam int LVL_W = $clog2(DEPTH + 1);

    dma_state_e        st;
    logic [ADDR_W-1:0] pend_q;
    logic [SIZE_W-1:0] size_q;
    logic [1:0]        flags_q;
    logic [LVL_W-1:0]  fifo_level;
    logic              push, pop, flush, ho_pulse, err_pulse;

    pp_dma_regfile #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_wr_en),
        .wr_sel    (reg_wr_addr),
        .wr_data   (reg_wr_data),
        .rd_sel    (reg_rd_addr),
        .state     (st),
        .ho_pulse  (ho_pulse),
        .err_pulse (err_pulse),
        .rd_data   (reg_rd_data),
        .pend_q    (pend_q),
        .size_q    (size_q),
        .flags_q   (flags_q)
    );

    pp_dma_fetch_fsm #(
        .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .DEPTH(DEPTH),
        .SAMPLE_BYTES(SAMPLE_BYTES), .LVL_W(LVL_W)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (reg_wr_en),
        .wr_sel     (reg_wr_addr),
        .wr_data    (reg_wr_data),
        .pend_q     (pend_q),
        .size_q     (size_q),
        .err_flag   (flags_q[FLAG_ERR]),
        .fifo_level (fifo_level),
        .mem_ack    (mem_ack),
        .state      (st),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .out_en     (out_en),
        .push       (push),
        .ho_pulse   (ho_pulse),
        .err_pulse  (err_pulse)
    );

    assign smp_valid = out_en && (fifo_level != '0);
    assign pop       = smp_take && smp_valid;
    assign flush     = err_pulse || (st == ST_HALT);

    pp_dma_smp_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (flush),
        .push  (push),
        .wdata (mem_rdata),
        .pop   (pop),
        .rdata (smp_data),
        .level (fifo_level)
    );

    assign irq_handoff = flags_q[FLAG_HANDOFF];
    assign irq_err     = flags_q[FLAG_ERR];
endmodule

// File: rtl/pp_dma_ptr_ctrl_chk.sv
module pp_dma_ptr_ctrl_chk
    import pp_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              out_en,
    input logic              smp_valid,
    input logic              irq_handoff,
    input logic              irq_err,
    input logic              reg_wr_en,
    input logic [1:0]        reg_wr_addr,
    input logic [1:0]        clr_bits,
    input dma_state_e        st,
    input logic [ADDR_W-1:0] pend_q,
    input logic [SIZE_W-1:0] size_q,
    input logic              ho_pulse
);
    a_r8_req_hold: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

    a_r8_drop_after_ack: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_ack |=> !mem_req);

    a_r12_valid_needs_en: assert property (@(posedge clk) disable iff (rst)
        smp_valid |-> out_en);

    a_r9_err_quiets: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_err) |-> !out_en && !mem_req && !smp_valid);

    a_r3_pending_zeroed: assert property (@(posedge clk) disable iff (rst)
        ho_pulse && !(reg_wr_en && reg_wr_addr == RA_NEXT) |=> pend_q == '0);

    a_r4_handoff_sticky: assert property (@(posedge clk) disable iff (rst)
        irq_handoff && !(reg_wr_en && reg_wr_addr == RA_FLAGS && clr_bits[FLAG_HANDOFF])
        |=> irq_handoff);

    a_r11_size_locked: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FETCH || st == ST_WAIT || st == ST_HALT) |=> $stable(size_q));
endmodule

bind pp_dma_ptr_ctrl pp_dma_ptr_ctrl_chk #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mem_req     (mem_req),
    .mem_ack     (mem_ack),
    .mem_addr    (mem_addr),
    .out_en      (out_en),
    .smp_valid   (smp_valid),
    .irq_handoff (irq_handoff),
    .irq_err     (irq_err),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_addr (reg_wr_addr),
    .clr_bits    (reg_wr_data[1:0]),
    .st          (st),
    .pend_q      (pend_q),
    .size_q      (size_q),
    .ho_pulse    (ho_pulse)
);

// File: tb/tb_pp_dma_ptr_ctrl.sv
module tb_pp_dma_ptr_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int S_IDLE = 0, S_ARMED = 1, S_FETCH = 2, S_WAIT = 3, S_HALT = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_wr_addr = 2'd0;
    logic [31:0] reg_wr_data = '0;
    logic [1:0]  reg_rd_addr = 2'd0;
    logic [31:0] reg_rd_data;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata;
    logic        smp_take = 1'b0;
    logic        smp_valid;
    logic [15:0] smp_data;
    logic        out_en, irq_handoff, irq_err;

    pp_dma_ptr_ctrl dut (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
        .reg_wr_data(reg_wr_data), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .smp_take(smp_take), .smp_valid(smp_valid), .smp_data(smp_data), .out_en(out_en),
        .irq_handoff(irq_handoff), .irq_err(irq_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    assign mem_rdata = mem_addr[15:0] ^ 16'hA5C3;

    int n_tests = 0;
    int n_fail  = 0;
    bit chk_on  = 1'b0;
    bit take_en = 1'b0;
    int n_beats = 0;

    // reference model state
    int          m_st;
    logic [31:0] m_act, m_pend;
    logic [15:0] m_size, m_cnt;
    logic [1:0]  m_flags;
    logic [15:0] m_q[$];

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic finish_run;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        logic        ho, er, psh, pop, wn, ws, wf;
        logic [31:0] n_act, n_pend;
        logic [15:0] n_cnt, n_size, pd;
        int          ns, lvl;
        if (rst) begin
            m_st = S_IDLE; m_act = '0; m_pend = '0; m_size = '0; m_cnt = '0;
            m_flags = '0; m_q.delete();
        end else begin
            ho = 0; er = 0; psh = 0; pd = '0;
            wn = reg_wr_en && reg_wr_addr == 2'd0;
            ws = reg_wr_en && reg_wr_addr == 2'd1;
            wf = reg_wr_en && reg_wr_addr == 2'd2;
            lvl = m_q.size();
            pop = smp_take && (m_st == S_FETCH || m_st == S_WAIT) && lvl > 0;
            ns = m_st; n_act = m_act; n_cnt = m_cnt; n_pend = m_pend; n_size = m_size;
            case (m_st)
                S_IDLE: if (wn && reg_wr_data != 0) begin n_act = reg_wr_data; n_cnt = 0; ns = S_ARMED; end
                S_ARMED: if (ws && reg_wr_data[15:0] != 0) begin n_cnt = 0; ns = S_FETCH; end
                S_FETCH: if (mem_ack) begin
                    pd = m_act[15:0] ^ 16'hA5C3;
                    if (m_cnt == m_size - 16'd1) begin
                        if (m_pend != 0) ho = 1; else er = 1;
                        n_act = m_pend; n_cnt = 0;
                    end else begin
                        n_act = m_act + 32'd2; n_cnt = m_cnt + 16'd1;
                    end
                    psh = !er;
                    ns = er ? S_HALT : S_WAIT;
                end
                S_WAIT: if (lvl < 2) ns = S_FETCH;
                default: if (!m_flags[1]) ns = S_IDLE;
            endcase
            if (er) n_pend = 0;
            else if (wn && m_st != S_IDLE && m_st != S_HALT) n_pend = reg_wr_data;
            else if (ho) n_pend = 0;
            if (ws && (m_st == S_IDLE || m_st == S_ARMED)) n_size = reg_wr_data[15:0];
            m_flags = (m_flags & ~(wf ? reg_wr_data[1:0] : 2'b00)) | {er, ho};
            if (er || m_st == S_HALT) m_q.delete();
            else begin
                if (pop) void'(m_q.pop_front());
                if (psh) m_q.push_back(pd);
            end
            if (mem_req && mem_ack) n_beats++;
            m_st = ns; m_act = n_act; m_cnt = n_cnt; m_pend = n_pend; m_size = n_size;
        end
    end

    // per-cycle comparison and consumer/memory drive, half a period after each edge
    initial begin
        int cyc = 0;
        forever begin
            logic        m_run;
            logic [31:0] m_rd;
            @(negedge clk);
            #1;
            m_run = (m_st == S_FETCH || m_st == S_WAIT);
            case (reg_rd_addr)
                2'd0: m_rd = m_pend;
                2'd1: m_rd = {16'd0, m_size};
                2'd2: m_rd = {30'd0, m_flags};
                default: m_rd = '0;
            endcase
            if (chk_on) begin
                check("R8 mem_req", {31'd0, mem_req}, {31'd0, m_st == S_FETCH});
                if (m_st == S_FETCH) check("R7 mem_addr", mem_addr, m_act);
                check("R9 out_en", {31'd0, out_en}, {31'd0, m_run});
                check("R12 smp_valid", {31'd0, smp_valid}, {31'd0, m_run && m_q.size() > 0});
                if (m_run && m_q.size() > 0) check("R12 smp_data", {16'd0, smp_data}, {16'd0, m_q[0]});
                check("R4 irq_handoff", {31'd0, irq_handoff}, {31'd0, m_flags[0]});
                check("R9 irq_err", {31'd0, irq_err}, {31'd0, m_flags[1]});
                check("R2 reg_rd_data", reg_rd_data, m_rd);
            end
            mem_ack  = (m_st == S_FETCH) && (cyc % 3 != 1);
            smp_take = take_en && (cyc % 4 != 3);
            cyc++;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_expect(input logic [1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_rd_addr = a;
        #2;
        check(tag, reg_rd_data, exp);
    endtask

    task automatic wait_flag(input int bitn);
        while (!m_flags[bitn]) @(negedge clk);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk_on = 1'b1;
        // R1 reset state
        rd_expect(2'd0, 32'd0, "R1 next after reset");
        rd_expect(2'd1, 32'd0, "R1 size after reset");
        rd_expect(2'd2, 32'd0, "R1 flags after reset");
        check("R1 out_en after reset", {31'd0, out_en}, 32'd0);
        check("R1 mem_req after reset", {31'd0, mem_req}, 32'd0);

        // R5 bring-up
        wr(2'd0, 32'd0);
        wr(2'd0, 32'h0000_1000);
        rd_expect(2'd0, 32'd0, "R5 first pointer goes active, pending stays zero");
        check("R5 outputs off in ARMED", {31'd0, out_en}, 32'd0);
        wr(2'd1, 32'd6);
        wr(2'd0, 32'h0000_2000);
        rd_expect(2'd0, 32'h0000_2000, "R2 pending reads last write");
        rd_expect(2'd1, 32'd6, "R11 size readback");
        repeat (10) @(negedge clk);
        check("R6 two samples prefetched", n_beats, 2);
        check("R6 first sample presented", {16'd0, smp_data}, {16'd0, 16'h1000 ^ 16'hA5C3});
        check("R8 no request while queue full", {31'd0, mem_req}, 32'd0);
        take_en = 1'b1;

        // on-time refills across buffers
        wait_flag(0);
        rd_expect(2'd0, 32'd0, "R3 pending cleared after first handoff");
        wr(2'd2, 32'd1);
        wr(2'd0, 32'h0000_3000);
        rd_expect(2'd0, 32'h0000_3000, "R2 refill readback before handoff");
        wr(2'd1, 32'd3);
        rd_expect(2'd1, 32'd6, "R11 size write ignored while running");
        wait_flag(0);
        rd_expect(2'd0, 32'd0, "R3 pending cleared after second handoff");
        wr(2'd2, 32'd1);
        rd_expect(2'd2, 32'd0, "R4 handoff flag cleared by writing one");
        wr(2'd0, 32'h0000_4000);
        wait_flag(0);
        wr(2'd2, 32'd1);

        // late refill: underrun
        wait_flag(1);
        @(negedge clk);
        check("R9 out_en off after underrun", {31'd0, out_en}, 32'd0);
        check("R9 no sample after underrun", {31'd0, smp_valid}, 32'd0);
        check("R9 error flag set", {31'd0, irq_err}, 32'd1);
        wr(2'd0, 32'h0000_5000);
        rd_expect(2'd0, 32'd0, "R10 pointer write ignored in halt");
        wr(2'd1, 32'd9);
        rd_expect(2'd1, 32'd6, "R10 size write ignored in halt");
        wr(2'd2, 32'd2);
        repeat (3) @(negedge clk);
        check("R10 outputs stay off after clear", {31'd0, out_en}, 32'd0);

        // restart
        wr(2'd0, 32'h0000_8000);
        wr(2'd1, 32'd2);
        wr(2'd0, 32'h0000_9000);
        wait_flag(0);
        rd_expect(2'd0, 32'd0, "R3 pending cleared after restart handoff");
        check("R5 running after restart", {31'd0, out_en}, 32'd1);
        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule